// File: doc/BRIEF.md
# Scalable-Width Lane Serializer and Gatherer

This block moves 32-bit dwords across a narrow lane group whose active width is picked at run time from 2, 4, 8, 16 or 32 lanes. On the send side each accepted dword is cut into bit-times of the active width and driven onto the lanes. A control flag travels beside every bit-time and marks whether that dword belongs to a control packet or a data packet. Packets are always whole dwords, so a narrow setting simply spends more bit-times per dword: 32/width of them.

The receive side has its own width setting, so the two directions of a link may differ. It gathers bit-times back into dwords and tags each one with the flag it arrived with. Width requests pass through a shadow register on each side. The send side adopts a new width only at a dword boundary outside a packet. The receive side adopts it only between dwords while the link is idle.

The send input is a valid/ready stream. The block pulls a dword when it is idle or in the final bit-time of the current dword. A requester that sees ready low must keep valid high and hold the dword and its flags unchanged until the transfer. Within a packet the requester keeps valid high from dword to dword, so the bit-times leave back to back. The receive output is valid-only and has no back-pressure, because a link cannot be paused mid-dword.

Top module: `narrow_link_codec`

## Requirements
- R1: The width codes give these lane counts: code 0 is 2 lanes, code 1 is 4, code 2 is 8, code 3 is 16, and codes 4 to 7 are 32. The send and receive directions each take their own code.
- R2: On the send side, each dword occupies exactly 32/width consecutive bit-times, and `lane_vld_out` is high for each of them.
- R3: Bit-time k of a dword carries dword bits [k*width +: width] on lanes [width-1:0]. The least significant bits go first.
- R4: Lanes at index width and above are 0 during every bit-time. All lanes are 0 when `lane_vld_out` is low.
- R5: `lane_ctl_out` equals the `tx_in_ctl` of the dword on every one of its bit-times, and is 0 when the link is idle.
- R6: `tx_in_ready` is high when the sender is idle or in the final bit-time of a dword, and low otherwise. The first bit-time of an accepted dword appears in the next cycle.
- R7: After reset both directions use 8 lanes. The lanes, `lane_ctl_out` and `lane_vld_out` are 0, `tx_in_ready` is 1, and `rx_out_valid` is 0.
- R8: A send-width request made during a packet takes effect only after the dword flagged `tx_in_last` has finished. All dwords of that packet keep the old width, and the next packet uses the new width.
- R9: One cycle after the final bit-time of a dword reaches the receiver, `rx_out_valid` is high for one cycle. `rx_out_data` then holds the reassembled dword, and `rx_out_ctl` holds the flag from its first bit-time.
- R10: A receive-width request is adopted only when no dword is partly gathered and `lane_vld_in` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_width_cfg | input | 3 | Requested send width code |
| tx_in_valid | input | 1 | Send dword offered |
| tx_in_ready | output | 1 | Send dword taken on this edge when valid |
| tx_in_data | input | 32 | Send dword |
| tx_in_ctl | input | 1 | Dword belongs to a control packet |
| tx_in_last | input | 1 | Final dword of its packet |
| lane_out | output | LANES | Outgoing lane group |
| lane_ctl_out | output | 1 | Control/data flag beside each outgoing bit-time |
| lane_vld_out | output | 1 | Outgoing bit-time present |
| rx_width_cfg | input | 3 | Requested receive width code |
| lane_in | input | LANES | Incoming lane group |
| lane_ctl_in | input | 1 | Control/data flag beside each incoming bit-time |
| lane_vld_in | input | 1 | Incoming bit-time present |
| rx_out_valid | output | 1 | Reassembled dword present |
| rx_out_data | output | 32 | Reassembled dword |
| rx_out_ctl | output | 1 | Reassembled dword is control |

## Verification
The assertions assume that the sender's requester holds valid, data and flags steady while it is stalled. They also assume that incoming bit-times arrive in whole dwords at the receive width. The bench drives the send stream from tasks that wait for ready before moving on, and it loops the lanes straight back into the receiver. It changes both width codes together, either in idle gaps or, for the deferred-change case, inside a packet that it streams back to back. This way the receiver never idles in the middle of a packet and both sides switch at the same packet boundary.

// File: rtl/nlk_pkg.sv
package nlk_pkg;
  localparam int unsigned DW_BITS   = 32;
  localparam int unsigned MIN_LANES = 2;
  localparam int unsigned CODE_W    = 3;
  localparam int unsigned BEAT_W    = $clog2(DW_BITS / MIN_LANES);

  typedef logic [CODE_W-1:0] wcode_t;
  typedef logic [BEAT_W-1:0] beat_t;

  localparam wcode_t RESET_CODE = wcode_t'(2);

  function automatic wcode_t clamp_code(wcode_t c, wcode_t maxc);
    return (c > maxc) ? maxc : c;
  endfunction

  function automatic int unsigned lanes_of(wcode_t c);
    return MIN_LANES << c;
  endfunction

  function automatic beat_t last_beat(wcode_t c);
    int unsigned n;
    n = (DW_BITS / MIN_LANES) >> c;
    return beat_t'(n - 1);
  endfunction
endpackage

// File: rtl/nlk_width_reg.sv
module nlk_width_reg
  import nlk_pkg::*;
#(
  parameter int unsigned LANES = 32
) (
  input  logic   clk,
  input  logic   rst_n,
  input  wcode_t cfg_in,
  input  logic   apply,
  output wcode_t active
);
  localparam wcode_t MAX_CODE = wcode_t'($clog2(LANES / MIN_LANES));

  wcode_t shadow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= RESET_CODE;
      active <= RESET_CODE;
    end else begin
      shadow <= clamp_code(cfg_in, MAX_CODE);
      if (apply) active <= shadow;
    end
  end
endmodule

// File: rtl/nlk_tx.sv
module nlk_tx
  import nlk_pkg::*;
#(
  parameter int unsigned LANES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  wcode_t             cfg_code,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DW_BITS-1:0] in_data,
  input  logic               in_ctl,
  input  logic               in_last,
  output logic [LANES-1:0]   lane_out,
  output logic               lane_ctl,
  output logic               lane_vld
);
  logic [DW_BITS-1:0] sh;
  beat_t              cnt;
  logic               busy, ctl_q, in_pkt;
  logic               final_beat, take, apply;
  wcode_t             active;
  logic [LANES-1:0]   lane_en;

  assign final_beat = busy && (cnt == last_beat(active));
  assign in_ready   = !busy || final_beat;
  assign take       = in_valid && in_ready;
  assign apply      = !in_pkt && (!busy || final_beat);

  nlk_width_reg #(.LANES(LANES)) u_wreg (
    .clk(clk), .rst_n(rst_n), .cfg_in(cfg_code), .apply(apply), .active(active)
  );

  for (genvar i = 0; i < int'(LANES); i++) begin : g_lane_en
    assign lane_en[i] = (i < int'(lanes_of(active)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh     <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      ctl_q  <= 1'b0;
      in_pkt <= 1'b0;
    end else if (take) begin
      sh     <= in_data;
      cnt    <= '0;
      busy   <= 1'b1;
      ctl_q  <= in_ctl;
      in_pkt <= !in_last;
    end else if (busy) begin
      if (final_beat) begin
        busy <= 1'b0;
      end else begin
        sh  <= sh >> lanes_of(active);
        cnt <= cnt + beat_t'(1);
      end
    end
  end

  assign lane_out = busy ? (sh[LANES-1:0] & lane_en) : '0;
  assign lane_ctl = busy & ctl_q;
  assign lane_vld = busy;

  // R6
  start_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> lane_vld);
  // R6
  input_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (in_valid && $stable(in_data) && $stable(in_ctl)));
  // R2
  mid_dword_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_vld && !final_beat) |-> !in_ready);
  // R8
  tx_width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_pkt |=> $stable(active));
  // R5
  ctl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_vld && $past(lane_vld) && !$past(final_beat)) |-> $stable(lane_ctl));
endmodule

// File: rtl/nlk_rx.sv
module nlk_rx
  import nlk_pkg::*;
#(
  parameter int unsigned LANES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  wcode_t             cfg_code,
  input  logic [LANES-1:0]   lane_in,
  input  logic               lane_ctl_in,
  input  logic               lane_vld_in,
  output logic               out_valid,
  output logic [DW_BITS-1:0] out_data,
  output logic               out_ctl
);
  beat_t              cnt;
  logic [DW_BITS-1:0] acc, bits;
  logic               ctl_q, apply;
  wcode_t             active;
  logic [LANES-1:0]   lane_en;

  assign apply = (cnt == '0) && !lane_vld_in;

  nlk_width_reg #(.LANES(LANES)) u_wreg (
    .clk(clk), .rst_n(rst_n), .cfg_in(cfg_code), .apply(apply), .active(active)
  );

  for (genvar i = 0; i < int'(LANES); i++) begin : g_lane_en
    assign lane_en[i] = (i < int'(lanes_of(active)));
  end

  assign bits = DW_BITS'(lane_in & lane_en) << (int'(cnt) * int'(lanes_of(active)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      acc       <= '0;
      ctl_q     <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ctl   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (lane_vld_in) begin
        if (cnt == last_beat(active)) begin
          out_valid <= 1'b1;
          out_data  <= acc | bits;
          out_ctl   <= (cnt == '0) ? lane_ctl_in : ctl_q;
          acc       <= '0;
          cnt       <= '0;
        end else begin
          acc <= acc | bits;
          cnt <= cnt + beat_t'(1);
          if (cnt == '0) ctl_q <= lane_ctl_in;
        end
      end
    end
  end

  // R9
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(lane_vld_in));
  // R10
  rx_width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> $stable(active));
endmodule

// File: rtl/narrow_link_codec.sv
module narrow_link_codec
  import nlk_pkg::*;
#(
  parameter int unsigned LANES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       tx_width_cfg,
  input  logic             tx_in_valid,
  output logic             tx_in_ready,
  input  logic [31:0]      tx_in_data,
  input  logic             tx_in_ctl,
  input  logic             tx_in_last,
  output logic [LANES-1:0] lane_out,
  output logic             lane_ctl_out,
  output logic             lane_vld_out,
  input  logic [2:0]       rx_width_cfg,
  input  logic [LANES-1:0] lane_in,
  input  logic             lane_ctl_in,
  input  logic             lane_vld_in,
  output logic             rx_out_valid,
  output logic [31:0]      rx_out_data,
  output logic             rx_out_ctl
);
  nlk_tx #(.LANES(LANES)) u_tx (
    .clk(clk), .rst_n(rst_n), .cfg_code(tx_width_cfg),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
    .in_ctl(tx_in_ctl), .in_last(tx_in_last),
    .lane_out(lane_out), .lane_ctl(lane_ctl_out), .lane_vld(lane_vld_out)
  );

  nlk_rx #(.LANES(LANES)) u_rx (
    .clk(clk), .rst_n(rst_n), .cfg_code(rx_width_cfg),
    .lane_in(lane_in), .lane_ctl_in(lane_ctl_in), .lane_vld_in(lane_vld_in),
    .out_valid(rx_out_valid), .out_data(rx_out_data), .out_ctl(rx_out_ctl)
  );

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_vld_out |-> (lane_out == '0 && !lane_ctl_out));
endmodule

// File: tb/test_narrow_link_codec.sv
`timescale 1ns/1ps
module test_narrow_link_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  tx_width_cfg = 3'd2, rx_width_cfg = 3'd2;
  logic        tx_in_valid = 1'b0, tx_in_ctl = 1'b0, tx_in_last = 1'b0;
  logic [31:0] tx_in_data = '0;
  logic        tx_in_ready;
  logic [31:0] lane_out;
  logic        lane_ctl_out, lane_vld_out;
  logic        rx_out_valid, rx_out_ctl;
  logic [31:0] rx_out_data;

  always #2.5 clk = ~clk;

  narrow_link_codec i_narrow_link_codec (
    .clk(clk), .rst_n(rst_n), .tx_width_cfg(tx_width_cfg),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_in_ctl(tx_in_ctl), .tx_in_last(tx_in_last),
    .lane_out(lane_out), .lane_ctl_out(lane_ctl_out), .lane_vld_out(lane_vld_out),
    .rx_width_cfg(rx_width_cfg), .lane_in(lane_out), .lane_ctl_in(lane_ctl_out),
    .lane_vld_in(lane_vld_out), .rx_out_valid(rx_out_valid),
    .rx_out_data(rx_out_data), .rx_out_ctl(rx_out_ctl)
  );

  typedef struct { logic [31:0] d; logic c; int w; } item_t;
  item_t lane_q[$];
  item_t rx_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int width_of(logic [2:0] c);
    return (c >= 3'd4) ? 32 : (2 << c);
  endfunction

  // lane-side monitor: R2 R3 R4 R5
  int beat = 0;
  item_t cur;
  bit lane_ok;
  always @(negedge clk) begin
    if (rst_n && lane_vld_out) begin
      logic [63:0] mask;
      if (beat == 0) begin
        if (lane_q.size() == 0) begin
          check(0, "R2 unexpected bit-time", lane_out, 32'h0);
          cur.d = '0; cur.c = 1'b0; cur.w = 32;
        end else cur = lane_q.pop_front();
        lane_ok = 1;
      end
      mask = (64'd1 << cur.w) - 64'd1;
      if (lane_ctl_out !== cur.c) lane_ok = 0;                                  // R5
      if ((64'(lane_out) & ~mask) != 0) lane_ok = 0;                            // R4
      if ((64'(lane_out) & mask) != ((64'(cur.d) >> (beat * cur.w)) & mask)) lane_ok = 0; // R3
      beat++;
      if (beat == 32 / cur.w) begin
        check(lane_ok, "R2/R3/R4/R5 lane dword", lane_out, cur.d);
        beat = 0;
      end
    end else if (rst_n && beat != 0) begin
      check(0, "R2 dword cut short", 32'(beat), 32'(32 / cur.w));
      beat = 0;
    end
  end

  // receive-side scoreboard: R9
  always @(negedge clk) begin
    if (rst_n && rx_out_valid) begin
      if (rx_q.size() == 0) check(0, "R9 unexpected output", rx_out_data, 32'h0);
      else begin
        item_t e;
        e = rx_q.pop_front();
        check(rx_out_data == e.d && rx_out_ctl == e.c, "R9 reassembled dword", rx_out_data, e.d);
      end
    end
  end

  // driver: streams one packet back to back
  task automatic send_pkt(int n, bit ctl, int w, int seed, int chg_code);
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.d = (32'(seed) * 32'h01030507) ^ (32'(i) * 32'h9E3779B9) ^ 32'hA5C3_0F12;
      it.c = ctl; it.w = w;
      tx_in_valid = 1'b1; tx_in_data = it.d; tx_in_ctl = ctl; tx_in_last = (i == n - 1);
      while (!tx_in_ready) @(negedge clk);
      lane_q.push_back(it); rx_q.push_back(it);
      @(negedge clk);
      if (i == 0 && chg_code >= 0) begin
        tx_width_cfg = 3'(chg_code); rx_width_cfg = 3'(chg_code);
      end
    end
    tx_in_valid = 1'b0; tx_in_last = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_width(logic [2:0] c);
    wait (!lane_vld_out);
    tx_width_cfg = c; rx_width_cfg = c;
    repeat (4) @(negedge clk);
  endtask

  task automatic drain();
    for (int k = 0; k < 200 && (lane_q.size() != 0 || rx_q.size() != 0 || lane_vld_out); k++)
      @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    check(lane_vld_out == 0 && lane_ctl_out == 0, "R7 idle flags in reset", 32'(lane_vld_out), 0);
    check(lane_out == 0, "R7 lanes zero in reset", lane_out, 0);
    check(tx_in_ready == 1, "R7 ready in reset", 32'(tx_in_ready), 1);
    check(rx_out_valid == 0, "R7 rx valid in reset", 32'(rx_out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: default width is 8 lanes
    send_pkt(2, 1, 8, 1, -1);
    send_pkt(4, 0, 8, 2, -1);
    drain();
    // R1 code 0: 2 lanes; R6 ready timing
    set_width(3'd0);
    tx_in_valid = 1'b1; tx_in_data = 32'h8000_0001; tx_in_ctl = 1'b1; tx_in_last = 1'b1;
    begin
      item_t it; it.d = 32'h8000_0001; it.c = 1'b1; it.w = 2;
      lane_q.push_back(it); rx_q.push_back(it);
    end
    @(negedge clk);
    tx_in_valid = 1'b0;
    check(tx_in_ready == 0 && lane_vld_out == 1, "R6 ready low mid dword", 32'(tx_in_ready), 0);
    repeat (15) @(negedge clk);
    check(tx_in_ready == 1 && lane_vld_out == 1, "R6 ready high on final bit-time", 32'(tx_in_ready), 1);
    repeat (2) @(negedge clk);
    send_pkt(1, 1, 2, 3, -1);
    send_pkt(3, 0, 2, 4, -1);
    drain();
    // R1 codes 1, 3, 4 and clamped 7
    set_width(3'd1); send_pkt(2, 1, 4, 5, -1); send_pkt(3, 0, 4, 6, -1); drain();
    set_width(3'd3); send_pkt(1, 1, 16, 7, -1); send_pkt(2, 0, 16, 8, -1); drain();
    set_width(3'd4); send_pkt(2, 1, 32, 9, -1); send_pkt(16, 0, 32, 10, -1); drain();
    set_width(3'd7); send_pkt(3, 0, 32, 11, -1); drain();
    // R8 / R10: request 4 lanes during a 16-lane packet
    set_width(3'd3);
    send_pkt(3, 0, 16, 12, 1);
    send_pkt(2, 1, 4, 13, -1);
    drain();
    check(lane_q.size() == 0 && rx_q.size() == 0, "R8/R10 all dwords delivered",
          32'(rx_q.size()), 0);
    check(beat == 0 && !lane_vld_out, "R2 link idle at end", 32'(beat), 0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule